// File: doc/BRIEF.md
# Event Timer Main Counter and Register File

This block keeps the global state of a multi-channel event timer. It owns the 64-bit main up-counter, the read-only capability words, and the global configuration (run enable and legacy route select). It also decodes a 1 KiB register window of 32-bit words. Accesses to channel registers are passed to the channel slots as strobes that carry a slot index and a word index. Each channel slot is a separate block.

The counter advances by one on every clock that has the tick enable high while the run enable is set. While the run enable is clear, the counter holds its value and still reads back that value. Either half of the counter can be loaded by a write. When the run enable goes from 0 to 1, counting resumes from the held value. On that edge the block sends a one-cycle arm pulse to every channel whose comparator is not all ones. Read data is registered and appears one clock after the request. On clocks with no read, the read data is zero.

Top module: `evt_timer_globals`

## Requirements
- R1: After reset the counter, the run enable, the legacy select, the read data and the arm pulses are all zero.
- R2: The counter rises by exactly one on each clock where the run enable is 1 and `tick_en_i` is 1. It holds otherwise. A carry from bit 31 propagates into the upper half.
- R3: A write to offset 0x0F0 loads counter bits 31:0, and a write to 0x0F4 loads bits 63:32. The other half is kept. On that clock the write replaces the increment. Writes are taken whether or not the counter runs.
- R4: A read issued on one clock returns its data on `rdata_o` after the next edge. A counter read returns the value the counter had before that edge. `rdata_o` is 0 after any clock without a read.
- R5: Offset 0x000 reads {vendor id[15:0], 1, 0, 1, channels-1 [4:0], revision 0x01}. Bit 15 flags legacy route capability and bit 13 flags a 64-bit counter. Offset 0x004 reads the tick period. Writes to both offsets change nothing.
- R6: Offset 0x010 stores only bit 0 (run enable) and bit 1 (legacy select); all other bits read 0. Offset 0x014 reads 0 and ignores writes.
- R7: A write that moves the run enable from 0 to 1 sets `arm_o[n]` for one clock for each channel n whose `cmp_max_i[n]` is 0. A write made while the run enable is already 1 gives no pulse.
- R8: The address 0x100 + 0x20*n + 4*w reaches channel n, word w (0..5). A read raises `ch_rd_o` and returns `ch_rdata_i`. A write raises `ch_wr_o`. Both strobes carry n on `ch_idx_o` and w on `ch_word_o`.
- R9: An access to a channel index at or above the channel count, or to word 6 or 7 of a slot, raises no strobe and reads 0.
- R10: A write to word 1 of a channel slot (the upper configuration word) raises no `ch_wr_o`. Reads of word 1 are still passed on.
- R11: Offset 0x020 reads `sts_i` zero-extended. On the clock of a write there, `sts_clr_o` carries the write data bits [channels-1:0]; otherwise it is 0.
- R12: A request whose address bits 1:0 are not 0, or one to an unmapped global offset, reads 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Counter step enable |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Byte address in the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| cnt_o | output | 64 | Main counter |
| glb_en_o | output | 1 | Run enable |
| legacy_o | output | 1 | Legacy route select |
| ch_rd_o | output | 1 | Channel read strobe |
| ch_wr_o | output | 1 | Channel write strobe |
| ch_idx_o | output | 5 | Channel slot index |
| ch_word_o | output | 3 | Word index within slot |
| ch_wdata_o | output | 32 | Write data to channel slots |
| ch_rdata_i | input | 32 | Read data from the addressed slot |
| sts_i | input | NCH | Per-channel interrupt status |
| sts_clr_o | output | NCH | Status clear mask strobe |
| cmp_max_i | input | NCH | Channel comparator is all ones |
| arm_o | output | NCH | Re-arm pulse on resume |

## Verification
The hardest case to reach is a carry that crosses bit 31 while the counter is running, because from reset that would take four billion ticks. The stimulus stops the counter and loads the low half with 0xFFFFFFFE and the high half with a marker. It then sets the run enable, so the carry happens two ticks later. The same enabling write also tests the arm pulse mask against a comparator pattern with mixed bits. A second enabling write, made while the counter is already running, checks that no new pulse is sent.

// File: rtl/evt_timer_globals.sv
module evt_timer_globals #(
  parameter int          NCH     = 3,
  parameter logic [31:0] TICK_FS = 32'd10_000_000,
  parameter logic [7:0]  REV     = 8'h01,
  parameter logic [15:0] VENDOR  = 16'h0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en_i,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [9:0]      addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic [63:0]     cnt_o,
  output logic            glb_en_o,
  output logic            legacy_o,
  output logic            ch_rd_o,
  output logic            ch_wr_o,
  output logic [4:0]      ch_idx_o,
  output logic [2:0]      ch_word_o,
  output logic [31:0]     ch_wdata_o,
  input  logic [31:0]     ch_rdata_i,
  input  logic [NCH-1:0]  sts_i,
  output logic [NCH-1:0]  sts_clr_o,
  input  logic [NCH-1:0]  cmp_max_i,
  output logic [NCH-1:0]  arm_o
);
  localparam int          IW     = 5;
  localparam logic [IW-1:0] NCH_V = IW'(NCH);
  localparam logic [9:0]  A_CAP  = 10'h000;
  localparam logic [9:0]  A_PER  = 10'h004;
  localparam logic [9:0]  A_CFG  = 10'h010;
  localparam logic [9:0]  A_STS  = 10'h020;
  localparam logic [9:0]  A_CLO  = 10'h0F0;
  localparam logic [9:0]  A_CHI  = 10'h0F4;
  localparam logic [31:0] CAP_LO = {VENDOR, 1'b1, 1'b0, 1'b1, 5'(NCH - 1), REV};

  logic          acc, rd, wr, in_ch, ch_hit;
  logic [IW-1:0] slot;
  logic [2:0]    word;
  logic [31:0]   rd_val;
  logic          en_q, leg_q;
  logic [63:0]   cnt_q;

  assign acc    = req_i && (addr_i[1:0] == 2'b00);
  assign rd     = acc && !we_i;
  assign wr     = acc && we_i;
  assign in_ch  = addr_i[9:8] != 2'b00;
  assign slot   = addr_i[9:5] - 5'd8;
  assign word   = addr_i[4:2];
  assign ch_hit = in_ch && (slot < NCH_V) && (word < 3'd6);

  assign ch_rd_o    = rd && ch_hit;
  assign ch_wr_o    = wr && ch_hit && (word != 3'd1);
  assign ch_idx_o   = slot;
  assign ch_word_o  = word;
  assign ch_wdata_o = wdata_i;
  assign sts_clr_o  = (wr && addr_i == A_STS) ? wdata_i[NCH-1:0] : '0;

  assign cnt_o    = cnt_q;
  assign glb_en_o = en_q;
  assign legacy_o = leg_q;

  always_comb begin
    rd_val = '0;
    if (in_ch) begin
      if (ch_hit) rd_val = ch_rdata_i;
    end else begin
      case (addr_i)
        A_CAP:   rd_val = CAP_LO;
        A_PER:   rd_val = TICK_FS;
        A_CFG:   rd_val = {30'd0, leg_q, en_q};
        A_STS:   rd_val = 32'(sts_i);
        A_CLO:   rd_val = cnt_q[31:0];
        A_CHI:   rd_val = cnt_q[63:32];
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      en_q    <= 1'b0;
      leg_q   <= 1'b0;
      rdata_o <= '0;
      arm_o   <= '0;
    end else begin
      rdata_o <= rd ? rd_val : '0;
      arm_o   <= '0;
      if (wr && addr_i == A_CFG) begin
        en_q  <= wdata_i[0];
        leg_q <= wdata_i[1];
        if (wdata_i[0] && !en_q) arm_o <= ~cmp_max_i;
      end
      if (wr && addr_i == A_CLO)      cnt_q[31:0]  <= wdata_i;
      else if (wr && addr_i == A_CHI) cnt_q[63:32] <= wdata_i;
      else if (en_q && tick_en_i)     cnt_q        <= cnt_q + 64'd1;
    end
  end
endmodule

// File: rtl/evt_timer_globals_chk.sv
module evt_timer_globals_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick_en_i,
  input logic           req_i,
  input logic           we_i,
  input logic [9:0]     addr_i,
  input logic [31:0]    rdata_o,
  input logic [63:0]    cnt_o,
  input logic           glb_en_o,
  input logic           ch_rd_o,
  input logic           ch_wr_o,
  input logic [4:0]     ch_idx_o,
  input logic [2:0]     ch_word_o,
  input logic [NCH-1:0] arm_o
);
  localparam logic [4:0] NCH_V = 5'(NCH);
  logic cw;
  assign cw = req_i && we_i && (addr_i == 10'h0F0 || addr_i == 10'h0F4);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en_o && !cw) |=> $stable(cnt_o));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en_o && tick_en_i && !cw) |=> (cnt_o == $past(cnt_o) + 64'd1));
  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (rdata_o == 32'd0));
  assert_arm_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_o != '0) |-> $rose(glb_en_o));
  assert_slot_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_rd_o || ch_wr_o) |-> (ch_idx_o < NCH_V && ch_word_o < 3'd6));
  assert_no_upper_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ch_wr_o |-> (ch_word_o != 3'd1));
endmodule

bind evt_timer_globals evt_timer_globals_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .rdata_o(rdata_o), .cnt_o(cnt_o), .glb_en_o(glb_en_o),
  .ch_rd_o(ch_rd_o), .ch_wr_o(ch_wr_o), .ch_idx_o(ch_idx_o),
  .ch_word_o(ch_word_o), .arm_o(arm_o)
);

// File: tb/evt_timer_globals_test.sv
module evt_timer_globals_test;
  localparam int          NCH = 4;
  localparam logic [31:0] PER = 32'h0098_9680;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n, tick, req, we;
  logic [9:0]     addr;
  logic [31:0]    wdata, rdata, ch_wdata, ch_rdata;
  logic [63:0]    cnt;
  logic           en, leg, ch_rd, ch_wr;
  logic [4:0]     ch_idx;
  logic [2:0]     ch_word;
  logic [NCH-1:0] sts, sts_clr, cmpmax, arm;

  evt_timer_globals #(.NCH(NCH), .TICK_FS(PER)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .cnt_o(cnt),
    .glb_en_o(en), .legacy_o(leg), .ch_rd_o(ch_rd), .ch_wr_o(ch_wr),
    .ch_idx_o(ch_idx), .ch_word_o(ch_word), .ch_wdata_o(ch_wdata),
    .ch_rdata_i(ch_rdata), .sts_i(sts), .sts_clr_o(sts_clr),
    .cmp_max_i(cmpmax), .arm_o(arm)
  );

  function automatic logic [31:0] stub(input logic [4:0] i, input logic [2:0] w);
    return 32'hC0DE_0000 | {16'h0, 3'b0, i, 5'b0, w};
  endfunction
  assign ch_rdata = stub(ch_idx, ch_word);

  int checks = 0, fails = 0;
  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [63:0]    m_cnt;
  logic           m_en, m_leg;
  logic [31:0]    m_rd;
  logic [NCH-1:0] m_arm;

  function automatic logic [31:0] ref_rd(input logic [9:0] a);
    int idx, w;
    if (a >= 10'h100) begin
      idx = (int'(a) >> 5) - 8;
      w   = (int'(a) >> 2) & 7;
      if (idx < NCH && w < 6) return stub(5'(idx), 3'(w));
      return 32'd0;
    end
    case (a)
      10'h000: return 32'h0000_A001 | ((NCH - 1) << 8);
      10'h004: return PER;
      10'h010: return {30'd0, m_leg, m_en};
      10'h020: return 32'(sts);
      10'h0F0: return m_cnt[31:0];
      10'h0F4: return m_cnt[63:32];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic ok;
    logic [63:0] ncnt;
    if (!rst_n) begin
      m_cnt = 0; m_en = 0; m_leg = 0; m_rd = 0; m_arm = 0;
    end else begin
      ok = req && addr[1:0] == 2'b00;
      m_rd = (ok && !we) ? ref_rd(addr) : 32'd0;
      ncnt = (m_en && tick) ? m_cnt + 1 : m_cnt;
      if (ok && we && addr == 10'h0F0) ncnt = {m_cnt[63:32], wdata};
      if (ok && we && addr == 10'h0F4) ncnt = {wdata, m_cnt[31:0]};
      m_arm = '0;
      if (ok && we && addr == 10'h010) begin
        if (wdata[0] && !m_en) m_arm = ~cmpmax;
        m_en = wdata[0];
        m_leg = wdata[1];
      end
      m_cnt = ncnt;
    end
    #1;
    chk("R1/R2/R3 counter", cnt, m_cnt);
    chk("R1/R6 enable", 64'(en), 64'(m_en));
    chk("R1/R6 legacy", 64'(leg), 64'(m_leg));
    chk("R1/R4 read data", 64'(rdata), 64'(m_rd));
    chk("R1/R7 arm", 64'(arm), 64'(m_arm));
  end

  task automatic idle();
    req = 0; we = 0; addr = '0; wdata = '0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); idle();
    chk(tag, 64'(rdata), 64'(exp));
  endtask

  task automatic probe(input logic [9:0] a, input logic w, input logic [31:0] d,
                       input logic erd, input logic ewr, input logic [4:0] eidx,
                       input logic [2:0] eword, input logic [NCH-1:0] eclr,
                       input string tag);
    @(negedge clk); req = 1; we = w; addr = a; wdata = d;
    #1;
    chk(tag, 64'({ch_rd, ch_wr}), 64'({erd, ewr}));
    if (erd || ewr) chk(tag, 64'({ch_idx, ch_word}), 64'({eidx, eword}));
    if (ewr) chk(tag, 64'(ch_wdata), 64'(d));
    chk(tag, 64'(sts_clr), 64'(eclr));
    @(negedge clk); idle();
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] held;
    rst_n = 0; tick = 1; sts = '0; cmpmax = '0; idle();
    repeat (3) @(negedge clk);
    chk("R1 counter at reset", cnt, 64'd0);
    chk("R1 arm at reset", 64'(arm), 64'd0);
    rst_n = 1;

    rd(10'h0F0, 32'd0, "R1 counter halted after reset");
    rd(10'h010, 32'd0, "R1 config after reset");

    rd(10'h000, 32'h0000_A301, "R5 capability low");
    rd(10'h004, PER, "R5 tick period");
    wr(10'h000, 32'h1234_5678);
    wr(10'h004, 32'h0);
    rd(10'h000, 32'h0000_A301, "R5 capability read-only");
    rd(10'h004, PER, "R5 period read-only");

    wr(10'h010, 32'hFFFF_FFFC);
    rd(10'h010, 32'd0, "R6 reserved config bits");
    wr(10'h014, 32'hFFFF_FFFF);
    rd(10'h014, 32'd0, "R6 upper config word");
    wr(10'h010, 32'h2);
    rd(10'h010, 32'h2, "R6 legacy select only");

    wr(10'h0F0, 32'hFFFF_FFFE);
    wr(10'h0F4, 32'h0000_0012);
    rd(10'h0F0, 32'hFFFF_FFFE, "R3 low half load while halted");
    rd(10'h0F4, 32'h0000_0012, "R3 high half load keeps low");

    cmpmax = 4'b0100;
    wr(10'h010, 32'h1);
    chk("R7 arm mask on resume", 64'(arm), 64'(4'b1011));
    repeat (3) @(negedge clk);
    rd(10'h0F4, 32'h0000_0013, "R2 carry into high half");
    wr(10'h010, 32'h1);
    chk("R7 no arm while running", 64'(arm), 64'd0);

    tick = 0;
    repeat (5) @(negedge clk);
    tick = 1;
    tick = 0; @(negedge clk); tick = 1;
    repeat (2) @(negedge clk);
    tick = 0; repeat (2) @(negedge clk); tick = 1;
    wr(10'h0F0, 32'h0000_0100);
    repeat (2) @(negedge clk);

    probe(10'h148, 1'b0, 32'h0, 1'b1, 1'b0, 5'd2, 3'd2, '0, "R8 channel read strobe");
    rd(10'h148, stub(5'd2, 3'd2), "R8 channel read data");
    probe(10'h150, 1'b1, 32'hAA55_00FF, 1'b0, 1'b1, 5'd2, 3'd4, '0, "R8 channel write strobe");
    probe(10'h16C, 1'b1, 32'h1, 1'b0, 1'b1, 5'd3, 3'd3, '0, "R8 last channel comparator high");

    probe(10'h180, 1'b0, 32'h0, 1'b0, 1'b0, 5'd0, 3'd0, '0, "R9 channel above count read");
    probe(10'h180, 1'b1, 32'h7, 1'b0, 1'b0, 5'd0, 3'd0, '0, "R9 channel above count write");
    rd(10'h3FC, 32'd0, "R9 top slot reads zero");
    probe(10'h118, 1'b1, 32'h7, 1'b0, 1'b0, 5'd0, 3'd0, '0, "R9 word 6 write");
    rd(10'h11C, 32'd0, "R9 word 7 reads zero");

    probe(10'h164, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 5'd0, 3'd0, '0, "R10 upper config write dropped");
    probe(10'h164, 1'b0, 32'h0, 1'b1, 1'b0, 5'd3, 3'd1, '0, "R10 upper config read passed");

    sts = 4'b1010;
    rd(10'h020, 32'h0000_000A, "R11 status read");
    probe(10'h020, 1'b1, 32'hFFFF_FFF6, 1'b0, 1'b0, 5'd0, 3'd0, 4'b0110, "R11 status clear strobe");

    wr(10'h010, 32'h0);
    @(negedge clk); req = 1; we = 0; addr = 10'h0F0;
    @(negedge clk); idle(); held = rdata;
    wr(10'h0F1, 32'h0);
    wr(10'h0F6, 32'h0);
    rd(10'h0F0, held, "R12 misaligned write ignored");
    rd(10'h0F2, 32'd0, "R12 misaligned read zero");
    rd(10'h0F8, 32'd0, "R12 unmapped offset");
    wr(10'h011, 32'h1);
    rd(10'h010, 32'd0, "R12 misaligned config write");

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule